// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block walks the column addresses of one SDRAM burst. A load strobe captures an 8-bit start column together with a burst length code and an ordering bit. From the next cycle on, the block presents one column per beat, and each asserted advance enable steps it to the next beat. Fixed-length bursts of 1, 2, 4 or 8 beats stay inside the aligned block of that size that holds the start column. The beats are ordered either by counting upward with wrap-around or by XOR-ing the beat index into the low address bits.

A full-page burst runs through all 256 columns of the row, wrapping from the top column back to zero. It continues until a terminate strobe arrives. A terminate strobe ends any burst early. A new load may arrive on any cycle, including in the middle of a burst, and the new burst starts at once. The block sits between a memory controller's command scheduler and the column address pins. It holds no data and does not decode commands.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted, and afterwards until the first load, valid_o and last_o are 0.
- R2: When load_i is 1 at a clock edge, valid_o is 1 and col_o equals the loaded start_col_i after that edge. This holds whatever the current burst is doing, and load_i takes priority over stop_i in the same cycle.
- R3: len_code_i selects the burst length: 0 gives 1 beat, 1 gives 2 beats, 2 gives 4 beats and 3 gives 8 beats. Any code from 4 to 7 selects a full-page burst.
- R4: With order bit 0 and length N, beat k presents the start column with its low log2(N) bits replaced by (start low bits + k) mod N. The upper bits keep their start value.
- R5: With order bit 1 and length N, beat k presents the start column with its low log2(N) bits XOR-ed with k.
- R6: In full-page mode, beat k presents (start + k) mod 256, the order bit is ignored, and the burst continues until stop_i or a new load.
- R7: last_o is 1 exactly while valid_o is 1 on beat N-1 of a fixed-length burst. It is never 1 in full-page mode.
- R8: While valid_o is 1 and advance_i, load_i and stop_i are all 0, col_o, valid_o and last_o keep their values.
- R9: Advancing on the last beat of a fixed-length burst drops valid_o on the next cycle.
- R10: stop_i without load_i drops valid_o on the next cycle.
- R11: Length code and order bit are sampled only on a load. Changing them during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load_i | input | 1 | Start a new burst at start_col_i |
| start_col_i | input | 8 | First column of the burst |
| len_code_i | input | 3 | Burst length code (see R3) |
| interleave_i | input | 1 | 0 = wrapping upward count, 1 = XOR ordering |
| advance_i | input | 1 | Step to the next beat |
| stop_i | input | 1 | Terminate the current burst |
| col_o | output | 8 | Column address of the current beat |
| valid_o | output | 1 | A burst beat is being presented |
| last_o | output | 1 | Current beat is the final one of a fixed burst |

## Verification
The assertions assume that the strobes are free of X after reset and that load_i is low while rst_n is low. Without that, the load-to-start-column property could see a stale start value on the first edge. The bench holds every strobe at zero through reset. It changes inputs only on the falling edge, and it includes mid-burst loads, stops and changes to the length and order inputs. Those cases exercise the priority and sampling rules that the properties describe.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int LEN_CODE_W = 3;
  localparam int MAX_FIXED_LOG = 3;
  typedef enum logic {ORD_WRAP = 1'b0, ORD_XOR = 1'b1} order_e;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [LEN_CODE_W-1:0] len_code,
  output logic [COL_W-1:0]      mask,
  output logic                  full
);
  always_comb begin
    full = (int'(len_code) > MAX_FIXED_LOG);
    mask = '1;
    if (!full) begin
      for (int i = 0; i < COL_W; i++) begin
        mask[i] = (i < int'(len_code));
      end
    end
  end
endmodule

// File: rtl/bcg_beat_ctrl.sv
module bcg_beat_ctrl
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             stop,
  input  logic             advance,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] mask_in,
  input  logic             full_in,
  input  order_e           order_in,
  output logic [COL_W-1:0] base_q,
  output logic [COL_W-1:0] beat_q,
  output logic [COL_W-1:0] mask_q,
  output order_e           order_q,
  output logic             active_q,
  output logic             last
);
  logic             full_q;
  logic             active_d;
  logic [COL_W-1:0] beat_d;
  logic             cfg_en;

  assign last   = active_q && !full_q && (beat_q == mask_q);
  assign cfg_en = load;

  always_comb begin
    active_d = active_q;
    beat_d   = beat_q;
    if (load) begin
      active_d = 1'b1;
      beat_d   = '0;
    end else if (stop) begin
      active_d = 1'b0;
    end else if (advance && active_q) begin
      if (last) active_d = 1'b0;
      else      beat_d   = beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else begin
      active_q <= active_d;
      beat_q   <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      mask_q  <= '0;
      full_q  <= 1'b0;
      order_q <= ORD_WRAP;
    end else if (cfg_en) begin
      base_q  <= start_col;
      mask_q  <= mask_in;
      full_q  <= full_in;
      order_q <= full_in ? ORD_WRAP : order_in;
    end
  end
endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  order_e           order,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] mixed;

  always_comb begin
    if (order == ORD_XOR) mixed = base ^ beat;
    else                  mixed = base + beat;
    col = (base & ~mask) | (mixed & mask);
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic [COL_W-1:0]      start_col_i,
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  interleave_i,
  input  logic                  advance_i,
  input  logic                  stop_i,
  output logic [COL_W-1:0]      col_o,
  output logic                  valid_o,
  output logic                  last_o
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] mask_q;
  order_e           order_q;
  order_e           order_in;

  assign order_in = interleave_i ? ORD_XOR : ORD_WRAP;

  bcg_len_decode #(.COL_W(COL_W)) i_len_decode (
    .len_code (len_code_i),
    .mask     (dec_mask),
    .full     (dec_full)
  );

  bcg_beat_ctrl #(.COL_W(COL_W)) i_beat_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_i),
    .stop      (stop_i),
    .advance   (advance_i),
    .start_col (start_col_i),
    .mask_in   (dec_mask),
    .full_in   (dec_full),
    .order_in  (order_in),
    .base_q    (base_q),
    .beat_q    (beat_q),
    .mask_q    (mask_q),
    .order_q   (order_q),
    .active_q  (valid_o),
    .last      (last_o)
  );

  bcg_addr_map #(.COL_W(COL_W)) i_addr_map (
    .base  (base_q),
    .beat  (beat_q),
    .mask  (mask_q),
    .order (order_q),
    .col   (col_o)
  );
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             advance_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  // R2
  p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> valid_o && (col_o == $past(start_col_i)));

  // R10
  p_stop_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i && !load_i |=> !valid_o);

  // R9
  p_last_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && last_o && advance_i && !load_i && !stop_i |=> !valid_o);

  // R7
  p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  // R8
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !advance_i && !load_i && !stop_i |=>
      valid_o && $stable(col_o) && $stable(last_o));

  // R1
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o && !load_i |=> !valid_o);
endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) i_bcg_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_i      (load_i),
  .start_col_i (start_col_i),
  .advance_i   (advance_i),
  .stop_i      (stop_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o)
);

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;
  localparam int COLS = 256;

  logic       clk;
  logic       rst_n;
  logic       load_i;
  logic [7:0] start_col_i;
  logic [2:0] len_code_i;
  logic       interleave_i;
  logic       advance_i;
  logic       stop_i;
  logic [7:0] col_o;
  logic       valid_o;
  logic       last_o;

  int checks = 0;
  int errors = 0;
  string ctx = "";

  // behavioural model state
  int m_act = 0;
  int m_s = 0;
  int m_k = 0;
  int m_n = 1;   // 0 means full page
  int m_il = 0;

  burst_col_gen #(.COL_W(8)) i_burst_col_gen (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .interleave_i(interleave_i),
    .advance_i(advance_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", ctx, tag, got, exp);
    end
  endtask

  function automatic int exp_col();
    int blk, off;
    if (m_n == 0) return (m_s + m_k) % COLS;
    off = m_s % m_n;
    blk = m_s - off;
    if (m_il != 0) return blk + (off ^ m_k);
    return blk + ((off + m_k) % m_n);
  endfunction

  task automatic compare();
    int ec;
    bit el;
    check(int'(valid_o) == m_act, "valid R2/R9/R10", int'(valid_o), m_act);
    if (m_act != 0) begin
      ec = exp_col();
      el = (m_n != 0) && (m_k == m_n - 1);
      check(int'(col_o) == ec, (m_n == 0) ? "col R6/R3" : ((m_il != 0) ? "col R5" : "col R4"),
            int'(col_o), ec);
      check(last_o == el, "last R7", int'(last_o), int'(el));
    end else begin
      check(last_o == 1'b0, "last idle R7", int'(last_o), 0);
    end
  endtask

  task automatic model_step();
    if (load_i) begin
      m_act = 1; m_s = int'(start_col_i); m_k = 0;
      m_n = (len_code_i < 3'd4) ? (1 << len_code_i) : 0;
      m_il = (m_n == 0) ? 0 : int'(interleave_i);
    end else if (stop_i) begin
      m_act = 0;
    end else if (advance_i && m_act != 0) begin
      if (m_n != 0 && m_k == m_n - 1) m_act = 0;
      else m_k = (m_k + 1) % COLS;
    end
  endtask

  task automatic cyc(input bit ld, input int st, input int lc, input bit il,
                     input bit adv, input bit sp);
    @(negedge clk);
    compare();
    load_i = ld; start_col_i = 8'(st); len_code_i = 3'(lc);
    interleave_i = il; advance_i = adv; stop_i = sp;
    @(posedge clk);
    model_step();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_i = 0; start_col_i = 0; len_code_i = 0;
    interleave_i = 0; advance_i = 0; stop_i = 0;
    repeat (3) @(negedge clk);
    ctx = "R1";
    check(valid_o == 1'b0, "reset valid R1", int'(valid_o), 0);
    check(last_o == 1'b0, "reset last R1", int'(last_o), 0);
    @(negedge clk) rst_n = 1'b1;
    cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 1, 0);

    // R8: hold without advance
    ctx = "R8";
    cyc(1, 8'h5D, 2, 1, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 1, 0);

    // R10 and R2: stop mid-burst, load beats stop
    ctx = "R10";
    cyc(1, 8'h10, 3, 0, 1, 0);
    cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 1, 0);
    ctx = "R2";
    cyc(1, 8'hA3, 3, 0, 1, 0);
    cyc(0, 0, 0, 0, 1, 0);
    cyc(1, 8'h47, 1, 1, 1, 1);
    cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 1, 0);

    // R6: full page wrap past column 255
    ctx = "R6";
    cyc(1, 8'hFC, 7, 1, 1, 0);
    for (int i = 0; i < 300; i++) cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 1, 0);

    // R3/R4/R5/R6/R7/R9: every start, code and order
    ctx = "sweep";
    for (int lc = 0; lc < 8; lc++) begin
      for (int il = 0; il < 2; il++) begin
        for (int st = 0; st < COLS; st++) begin
          int beats = (lc < 4) ? (1 << lc) : 12;
          cyc(1, st, lc, il[0], 1, 0);
          for (int b = 0; b < beats; b++) cyc(0, 0, 0, 0, 1, (lc >= 4) && (b == beats - 1));
          cyc(0, 0, 0, 0, 0, 0);
        end
      end
    end

    // R11 plus random mixes: config inputs change mid-burst
    ctx = "R11";
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 8) == 0, int'($urandom % COLS), int'($urandom % 8),
          1'($urandom % 2), ($urandom % 4) != 0, ($urandom % 20) == 0);
    end
    cyc(0, 0, 0, 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule